// File: doc/BRIEF.md
# Word-Pointer Buffer Window

This block gives a host a narrow view into a shared transfer buffer of 128 words of 32 bits, which is 512 bytes. The host first writes a control word that picks the direction of its accesses, turns pointer stepping on or off, and sets the word pointer. After that, one data register moves consecutive words in or out of the buffer. When stepping is on, each access that matches the chosen direction moves the pointer forward by one word. After the last word, the pointer returns to word 0.

A serial sequencer uses the same array through a second, word-addressed port. That port has its own read and write strobes and its own registered read data. If the sequencer and the host write the same word in the same cycle, the sequencer's value is kept. Byte n of the buffer is stored in word n/4, in lane n%4, with lane 0 in bits 7:0. A short final word therefore fills its low-order lanes first.

Top module: `dbuf_window`

## Requirements
- R1: After reset, `cfg_rdata` reads 0: the direction is host-read, stepping is off and the pointer is 0.
- R2: A `cfg_we` cycle loads three fields. Bit 31 is the direction (1 means the host writes the buffer, 0 means the host reads it). Bit 30 is the stepping enable. The low log2(depth) bits of field 7:0 are the pointer, so 0xFF gives 127. From the next cycle, `cfg_rdata` shows exactly these fields, and every other bit reads 0.
- R3: When stepping is on, a data access that matches the direction advances the pointer by one. A matching access is `dat_we` in write direction or `dat_re` in read direction. The pointer goes from 127 back to 0.
- R4: When stepping is off, data accesses leave the pointer unchanged.
- R5: In write direction, `dat_we` stores `dat_wdata` into the word at the pointer. In the same direction, `dat_re` returns that word but does not move the pointer.
- R6: In read direction, `dat_we` is ignored. No buffer word changes and the pointer does not move.
- R7: `dat_re` places the word at the pointer on `dat_rdata` in the following cycle. That value holds until the next `dat_re`.
- R8: If `cfg_we` and a data access fall in the same cycle, the access uses the old pointer and the old direction. The pointer then takes the newly written value and does not step.
- R9: On the sequencer port, `seq_en` with `seq_we` writes `seq_wdata` to word `seq_addr`. `seq_en` without `seq_we` places that word on `seq_rdata` in the following cycle.
- R10: If both ports write the same word in one cycle, the word keeps the sequencer's data. The host pointer still steps as R3 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word: direction, stepping enable, pointer |
| cfg_rdata | output | 32 | Current control word |
| dat_we | input | 1 | Host data write strobe |
| dat_wdata | input | 32 | Host write data |
| dat_re | input | 1 | Host data read strobe |
| dat_rdata | output | 32 | Host read data, registered |
| seq_en | input | 1 | Sequencer access strobe |
| seq_we | input | 1 | Sequencer write select |
| seq_addr | input | 7 | Sequencer word address |
| seq_wdata | input | 32 | Sequencer write data |
| seq_rdata | output | 32 | Sequencer read data, registered |

## Verification
Some properties are checked on every cycle through the control readback. These are the pointer and field load, a single step on each matching access, a frozen pointer on every other access, and the holding of host read data between reads. Other behaviour concerns the array contents, which only the scenarios can show. These include the full fill and readback over all 128 words across the wrap, the ignored write in read direction, the old-pointer rule when a control write meets a data access, and the sequencer winning a same-word write.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  localparam int CFG_W       = 32;
  localparam int CFG_DIR_BIT = 31;
  localparam int CFG_INC_BIT = 30;
  localparam int CFG_PTR_W   = 8;

  typedef enum logic {
    DIR_HOST_RD = 1'b0,
    DIR_HOST_WR = 1'b1
  } dbuf_dir_e;

  typedef struct packed {
    dbuf_dir_e dir;
    logic      inc;
  } dbuf_mode_t;
endpackage

// File: rtl/dbuf_ptr_ctl.sv
module dbuf_ptr_ctl
  import dbuf_pkg::*;
#(
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             dat_we,
  input  logic             dat_re,
  output logic [PTR_W-1:0] ptr,
  output logic             host_wr,
  output logic [CFG_W-1:0] cfg_rdata
);
  dbuf_mode_t       mode_q, mode_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             hit;

  // an access counts only when it matches the selected direction
  assign hit     = (mode_q.dir == DIR_HOST_WR) ? dat_we : dat_re;
  assign host_wr = (mode_q.dir == DIR_HOST_WR) && dat_we;
  assign ptr     = ptr_q;

  always_comb begin
    mode_d = mode_q;
    ptr_d  = ptr_q;
    if (cfg_we) begin
      mode_d.dir = dbuf_dir_e'(cfg_wdata[CFG_DIR_BIT]);
      mode_d.inc = cfg_wdata[CFG_INC_BIT];
      ptr_d      = cfg_wdata[PTR_W-1:0];
    end else if (mode_q.inc && hit) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{dir: DIR_HOST_RD, inc: 1'b0};
      ptr_q  <= '0;
    end else begin
      mode_q <= mode_d;
      ptr_q  <= ptr_d;
    end
  end

  always_comb begin
    cfg_rdata              = '0;
    cfg_rdata[CFG_DIR_BIT] = mode_q.dir;
    cfg_rdata[CFG_INC_BIT] = mode_q.inc;
    cfg_rdata[PTR_W-1:0]   = ptr_q;
  end
endmodule

// File: rtl/dbuf_ram.sv
module dbuf_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] a_rdata_q, a_rdata_d, b_rdata_q, b_rdata_d;
  logic          b_wr, a_wr;

  assign b_wr = b_en && b_we;
  // sequencer port wins a same-word write
  assign a_wr = a_we && !(b_wr && (b_addr == a_addr));

  always_ff @(posedge clk) begin
    if (b_wr) mem[b_addr] <= b_wdata;
    if (a_wr) mem[a_addr] <= a_wdata;
  end

  always_comb begin
    a_rdata_d = a_re ? mem[a_addr] : a_rdata_q;
    b_rdata_d = (b_en && !b_we) ? mem[b_addr] : b_rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata_q <= '0;
      b_rdata_q <= '0;
    end else begin
      a_rdata_q <= a_rdata_d;
      b_rdata_q <= b_rdata_d;
    end
  end

  assign a_rdata = a_rdata_q;
  assign b_rdata = b_rdata_q;
endmodule

// File: rtl/dbuf_window.sv
module dbuf_window
  import dbuf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             dat_we,
  input  logic [DW-1:0]    dat_wdata,
  input  logic             dat_re,
  output logic [DW-1:0]    dat_rdata,
  input  logic             seq_en,
  input  logic             seq_we,
  input  logic [AW-1:0]    seq_addr,
  input  logic [DW-1:0]    seq_wdata,
  output logic [DW-1:0]    seq_rdata
);
  logic [AW-1:0] ptr;
  logic          host_wr;

  dbuf_ptr_ctl #(.PTR_W(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .dat_we(dat_we), .dat_re(dat_re),
    .ptr(ptr), .host_wr(host_wr), .cfg_rdata(cfg_rdata)
  );

  dbuf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .a_we(host_wr), .a_re(dat_re), .a_addr(ptr),
    .a_wdata(dat_wdata), .a_rdata(dat_rdata),
    .b_en(seq_en), .b_we(seq_we), .b_addr(seq_addr),
    .b_wdata(seq_wdata), .b_rdata(seq_rdata)
  );
endmodule

// File: rtl/dbuf_window_chk.sv
module dbuf_window_chk
  import dbuf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             dat_we,
  input logic             dat_re,
  input logic [DW-1:0]    dat_rdata
);
  localparam logic [CFG_W-1:0] LOAD_MASK =
    (CFG_W'(1) << CFG_DIR_BIT) | (CFG_W'(1) << CFG_INC_BIT) | ((CFG_W'(1) << AW) - 1);

  logic [AW-1:0] cur_ptr;
  logic          match;
  assign cur_ptr = cfg_rdata[AW-1:0];
  assign match   = cfg_rdata[CFG_DIR_BIT] ? dat_we : dat_re;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & LOAD_MASK));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && cfg_rdata[CFG_INC_BIT] && match) |=> cur_ptr == AW'($past(cur_ptr) + 1'b1));

  // R4, R5, R6: no step without a matching access and stepping on
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !(cfg_rdata[CFG_INC_BIT] && match)) |=> $stable(cfg_rdata));

  p_rdhold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_re |=> $stable(dat_rdata));
endmodule

bind dbuf_window dbuf_window_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .dat_we(dat_we), .dat_re(dat_re), .dat_rdata(dat_rdata)
);

// File: tb/dbuf_window_test.sv
`timescale 1ns/1ps
module dbuf_window_test;
  localparam int N = 128;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, dat_we, dat_re, seq_en, seq_we;
  logic [31:0] cfg_wdata, cfg_rdata, dat_wdata, dat_rdata, seq_wdata, seq_rdata;
  logic [6:0]  seq_addr;
  int          checks = 0, errors = 0;
  bit          done = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  dbuf_window uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_re(dat_re), .dat_rdata(dat_rdata),
    .seq_en(seq_en), .seq_we(seq_we), .seq_addr(seq_addr), .seq_wdata(seq_wdata),
    .seq_rdata(seq_rdata)
  );

  function automatic logic [31:0] pat_a(int i);
    return (32'(i) * 32'h0103_0507) ^ 32'hA5A5_5A5A;
  endfunction
  function automatic logic [31:0] pat_b(int i);
    return ~(32'(i) * 32'h0011_2233) + 32'(i);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 0; dat_we = 0; dat_re = 0; seq_en = 0; seq_we = 0;
  endtask
  task automatic cfg_write(logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_wdata = d;
    @(negedge clk); idle();
  endtask
  task automatic host_write(logic [31:0] d);
    @(negedge clk); dat_we = 1; dat_wdata = d;
    @(negedge clk); idle();
  endtask
  task automatic host_read(output logic [31:0] d);
    @(negedge clk); dat_re = 1;
    @(negedge clk); d = dat_rdata; idle();
  endtask
  task automatic seq_write(logic [6:0] a, logic [31:0] d);
    @(negedge clk); seq_en = 1; seq_we = 1; seq_addr = a; seq_wdata = d;
    @(negedge clk); idle();
  endtask
  task automatic seq_read(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); seq_en = 1; seq_we = 0; seq_addr = a;
    @(negedge clk); d = seq_rdata; idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); cfg_wdata = 0; dat_wdata = 0; seq_wdata = 0; seq_addr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset control", cfg_rdata, 32'h0);

    // R2: field load, pointer modulo depth, other bits zero
    cfg_write(32'hFFFF_FFFF);
    chk("R2 load all ones", cfg_rdata, 32'hC000_007F);
    cfg_write(32'h0000_0105);
    chk("R2 load ptr 5", cfg_rdata, 32'h0000_0005);

    // R5, R3: fill whole buffer with stepping, pointer wraps to 0
    cfg_write(32'hC000_0000);
    for (int i = 0; i < N; i++) host_write(pat_a(i));
    chk("R3 wrap after fill", cfg_rdata, 32'hC000_0000);
    for (int i = 0; i < N; i++) begin
      seq_read(7'(i), rd);
      chk("R5 R9 host word via sequencer", rd, pat_a(i));
    end

    // R9, R7, R3: sequencer fills, host reads from 120 across wrap
    for (int i = 0; i < N; i++) seq_write(7'(i), pat_b(i));
    cfg_write(32'h4000_0078);
    for (int i = 0; i < N; i++) begin
      host_read(rd);
      chk("R7 R9 host read", rd, pat_b((120 + i) % N));
    end
    chk("R3 ptr after full read", cfg_rdata, 32'h4000_0078);
    repeat (3) @(negedge clk);
    chk("R7 read data holds", dat_rdata, pat_b(119));

    // R4: stepping off
    cfg_write(32'h8000_0007);
    host_write(32'h1111_1111);
    host_write(32'h2222_2222);
    chk("R4 ptr frozen", cfg_rdata, 32'h8000_0007);
    seq_read(7, rd);
    chk("R4 last write kept", rd, 32'h2222_2222);

    // R5: read in write direction does not step
    cfg_write(32'hC000_0007);
    host_read(rd);
    chk("R5 read in write dir", rd, 32'h2222_2222);
    chk("R5 no step on read", cfg_rdata, 32'hC000_0007);

    // R6: write ignored in read direction
    cfg_write(32'h4000_0003);
    host_write(32'hDEAD_BEEF);
    chk("R6 ptr unchanged", cfg_rdata, 32'h4000_0003);
    seq_read(3, rd);
    chk("R6 word unchanged", rd, pat_b(3));

    // R8: control write same cycle as data write
    cfg_write(32'hC000_000A);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = 32'hC000_0014; dat_we = 1; dat_wdata = 32'h0BAD_F00D;
    @(negedge clk); idle();
    chk("R8 ptr takes new value", cfg_rdata, 32'hC000_0014);
    seq_read(10, rd);
    chk("R8 old ptr used", rd, 32'h0BAD_F00D);
    seq_read(20, rd);
    chk("R8 new ptr word untouched", rd, pat_b(20));

    // R10: same-word collision
    cfg_write(32'hC000_0005);
    @(negedge clk);
    dat_we = 1; dat_wdata = 32'h1234_5678;
    seq_en = 1; seq_we = 1; seq_addr = 5; seq_wdata = 32'h8765_4321;
    @(negedge clk); idle();
    chk("R10 host ptr stepped", cfg_rdata, 32'hC000_0006);
    seq_read(5, rd);
    chk("R10 sequencer wins", rd, 32'h8765_4321);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule